// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the host-side master for an 8-bit parallel flash device. A requester hands it one operation at a time (byte program, sector erase, whole-array erase, identifier read or return-to-read) and the block expands that operation into the unlock and command write cycles the flash needs. It drives chip select, write strobe, output enable, a 16-bit address and a split data bus with separate out, in and drive-enable signals. Every phase of a bus cycle is stretched to a parameterised number of system clocks. The address is set up before the write strobe falls and kept steady while it is low. The data stays driven until after the strobe rises.

The block does not watch for the end of a program or erase. After the last write strobe of such an operation rises, it emits a one-cycle hand-off pulse and the address that a completion poller should watch. Program and erase requests that arrive during a start-up window, which is counted in clocks from reset, are held until the window has passed. Identifier reads and return-to-read are never held.

The controller has five states. IDLE accepts a request. HOLDOFF waits out the start-up window. ISSUE loads one bus cycle and starts the timer. BUSWAIT waits for the timer to finish. WRAP raises the completion pulses. The transitions are: IDLE to HOLDOFF (a program or erase request while the window is still open), IDLE to ISSUE (any other accepted request), HOLDOFF to ISSUE (window over), ISSUE to BUSWAIT (always), BUSWAIT to ISSUE (cycle done, more cycles remain), BUSWAIT to WRAP (final cycle done) and WRAP to IDLE (always). The bus timer has its own phases: IDLE, SETUP, WLOW, HOLD, READ and GAP.

Top module: `flash_cmd_master`

## Requirements
- R1: After reset, chip select, write strobe and output enable are all high (inactive), the data bus is not driven, `busy` is low and `req_ready` is high.
- R2: Op code 0 (program) produces exactly four write cycles, in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the requested address and data byte.
- R3: Op code 1 (sector erase) produces exactly six write cycles: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the requested address with its low 12 bits cleared, with data 30h.
- R4: Op code 2 (chip erase) produces the same first five cycles as R3, then a sixth cycle of 5555h/10h.
- R5: Op code 3 (identifier read) produces three writes (5555h/AAh, 2AAAh/55h, 5555h/90h), then reads address 0 and then address 1, then one write of 5555h/F0h. `resp_valid` then pulses for one cycle, with `resp_mfr` holding the byte read at address 0 and `resp_dev` the byte read at address 1.
- R6: Op code 4 (return-to-read), and any code from 5 to 7, produces a single write of 5555h/F0h and no poll hand-off.
- R7: The write strobe stays low for exactly WE_LOW_CYC clocks. The address is unchanged from the clock before the falling edge through the whole low time. The data is driven and unchanged across the rising edge.
- R8: While the write strobe is low, output enable is high and chip select is low. During a read cycle the data bus is not driven.
- R9: No write strobe of a program or erase falls within the first LOCKOUT_CYC clocks after reset. An identifier read issued right after reset starts without that delay.
- R10: `poll_start` pulses once, after the last write of a program or erase and never for other operations. With it, `poll_addr` gives the program address, the sector-aligned address for a sector erase, or 0 for a chip erase.
- R11: `req_ready` is high only in IDLE. `busy` is high from the cycle after acceptance until the operation ends. A `req_valid` asserted while busy is ignored, and no extra bus cycle follows. Chip select is high and the data bus is undriven whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 id read, 4 return-to-read) |
| req_addr | input | 16 | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| busy | output | 1 | Operation in progress |
| resp_valid | output | 1 | One-cycle pulse: identifier bytes valid |
| resp_mfr | output | 8 | Byte read at address 0 |
| resp_dev | output | 8 | Byte read at address 1 |
| poll_start | output | 1 | One-cycle pulse: start completion polling |
| poll_addr | output | 16 | Address to poll |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | 16 | Flash address |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | High while the block drives the data bus |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
A wrong step index or a wrong op decode shows up at once as a wrong address/data pair on the write strobe that follows. A counter that misses its terminal value shows up as a wrong count of write cycles before `busy` falls, well within one operation. A bus-timer phase entered in the wrong order shows up in the same bus cycle, either as a strobe width other than WE_LOW_CYC or as data leaving the bus before the rising edge. A start-up window counter that ends early shows up only on the first program or erase after reset, as a strobe falling too soon. For that reason the bench issues such a request straight after an identifier read that follows reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        OP_PROG = 3'd0,
        OP_SECT = 3'd1,
        OP_CHIP = 3'd2,
        OP_IDRD = 3'd3,
        OP_RST  = 3'd4
    } fop_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WLOW,
        PH_HOLD,
        PH_READ,
        PH_GAP
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLDOFF,
        ST_ISSUE,
        ST_BUSWAIT,
        ST_WRAP
    } ctl_e;

    localparam logic [15:0] UNLOCK_A = 16'h5555;
    localparam logic [15:0] UNLOCK_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A    = 8'hAA;
    localparam logic [7:0]  KEY_B    = 8'h55;
    localparam logic [7:0]  CMD_PROG = 8'hA0;
    localparam logic [7:0]  CMD_ERSU = 8'h80;
    localparam logic [7:0]  CMD_SECT = 8'h30;
    localparam logic [7:0]  CMD_CHIP = 8'h10;
    localparam logic [7:0]  CMD_IDEN = 8'h90;
    localparam logic [7:0]  CMD_EXIT = 8'hF0;

    function automatic logic is_pe(input logic [2:0] op);
        return (op == OP_PROG) || (op == OP_SECT) || (op == OP_CHIP);
    endfunction

endpackage

// File: rtl/fcm_lockout.sv
module fcm_lockout #(
    parameter int LOCKOUT_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int LCNT_W = $clog2(LOCKOUT_CYC + 1);

    logic [LCNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
            done  <= (cnt_q == LCNT_W'(LOCKOUT_CYC - 1));
        end
    end

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/fcm_seq_gen.sv
module fcm_seq_gen
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SECT_BITS = 12
) (
    input  logic [2:0]        op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] uaddr,
    input  logic [7:0]        udata,
    output logic              st_rd,
    output logic              st_last,
    output logic [ADDR_W-1:0] st_addr,
    output logic [7:0]        st_data
);
    localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_BITS) - 1'b1);

    logic [ADDR_W-1:0] pre_addr;
    logic [7:0]        pre_data;
    logic [7:0]        third_cmd;

    always_comb begin
        unique case (op)
            OP_PROG: third_cmd = CMD_PROG;
            OP_SECT, OP_CHIP: third_cmd = CMD_ERSU;
            default: third_cmd = CMD_IDEN;
        endcase
        unique case (step)
            3'd1, 3'd4: begin pre_addr = ADDR_W'(UNLOCK_B); pre_data = KEY_B; end
            3'd2:       begin pre_addr = ADDR_W'(UNLOCK_A); pre_data = third_cmd; end
            default:    begin pre_addr = ADDR_W'(UNLOCK_A); pre_data = KEY_A; end
        endcase
    end

    always_comb begin
        st_rd   = 1'b0;
        st_last = 1'b0;
        st_addr = pre_addr;
        st_data = pre_data;
        unique case (op)
            OP_PROG: begin
                if (step == 3'd3) begin
                    st_addr = uaddr;
                    st_data = udata;
                    st_last = 1'b1;
                end
            end
            OP_SECT: begin
                if (step == 3'd5) begin
                    st_addr = uaddr & SECT_MASK;
                    st_data = CMD_SECT;
                    st_last = 1'b1;
                end
            end
            OP_CHIP: begin
                if (step == 3'd5) begin
                    st_addr = ADDR_W'(UNLOCK_A);
                    st_data = CMD_CHIP;
                    st_last = 1'b1;
                end
            end
            OP_IDRD: begin
                if (step == 3'd3 || step == 3'd4) begin
                    st_rd   = 1'b1;
                    st_addr = ADDR_W'(step == 3'd4);
                    st_data = 8'h00;
                end else if (step == 3'd5) begin
                    st_addr = ADDR_W'(UNLOCK_A);
                    st_data = CMD_EXIT;
                    st_last = 1'b1;
                end
            end
            default: begin
                st_addr = ADDR_W'(UNLOCK_A);
                st_data = CMD_EXIT;
                st_last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fcm_bus_timer.sv
module fcm_bus_timer
    import flash_cmd_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int WE_LOW_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int GAP_CYC    = 2,
    parameter int RD_CYC     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_rd,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic drive,
    output logic sample,
    output logic done
);
    localparam int MAX_AB = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
    localparam int MAX_CD = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int MAX_AD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MAX_ALL = (MAX_AD > RD_CYC) ? MAX_AD : RD_CYC;
    localparam int CNT_W  = $clog2(MAX_ALL + 1);

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    function automatic logic [CNT_W-1:0] span(input phase_e p);
        unique case (p)
            PH_SETUP: return CNT_W'(SETUP_CYC - 1);
            PH_WLOW:  return CNT_W'(WE_LOW_CYC - 1);
            PH_HOLD:  return CNT_W'(HOLD_CYC - 1);
            PH_READ:  return CNT_W'(RD_CYC - 1);
            PH_GAP:   return CNT_W'(GAP_CYC - 1);
            default:  return '0;
        endcase
    endfunction

    function automatic phase_e follow(input phase_e p);
        unique case (p)
            PH_SETUP: return PH_WLOW;
            PH_WLOW:  return PH_HOLD;
            PH_HOLD:  return PH_GAP;
            PH_READ:  return PH_GAP;
            default:  return PH_IDLE;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = start_rd ? PH_READ : PH_SETUP;
                    cnt_d   = span(phase_d);
                end
            end
            default: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    phase_d = follow(phase_q);
                    cnt_d   = span(phase_d);
                end
            end
        endcase
    end

    always_comb begin
        ce_n   = (phase_q == PH_IDLE) || (phase_q == PH_GAP);
        we_n   = (phase_q != PH_WLOW);
        oe_n   = (phase_q != PH_READ);
        drive  = (phase_q == PH_SETUP) || (phase_q == PH_WLOW) || (phase_q == PH_HOLD);
        sample = (phase_q == PH_READ) && (cnt_q == '0);
        done   = (phase_q == PH_GAP) && (cnt_q == '0);
    end

    // R7
    fall_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(phase_q) == PH_SETUP);

    // R11
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> phase_q == PH_IDLE);

endmodule

// File: rtl/flash_cmd_master.sv
module flash_cmd_master
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SECT_BITS  = 12,
    parameter int CLK_NS     = 10,
    parameter int MIN_WE_NS  = 6,
    parameter int POWERUP_NS = 100000,
    parameter int SETUP_CYC  = 1,
    parameter int WE_LOW_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int GAP_CYC    = 2,
    parameter int RD_CYC     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              req_ready,
    output logic              busy,
    output logic              resp_valid,
    output logic [7:0]        resp_mfr,
    output logic [7:0]        resp_dev,
    output logic              poll_start,
    output logic [ADDR_W-1:0] poll_addr,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in
);
    localparam int LOCKOUT_CYC = (POWERUP_NS + CLK_NS - 1) / CLK_NS;
    localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_BITS) - 1'b1);

    initial begin
        we_floor_chk: assert (WE_LOW_CYC * CLK_NS >= MIN_WE_NS && MIN_WE_NS > 5);
    end

    ctl_e              state_q, state_d;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] uaddr_q;
    logic [7:0]        udata_q;
    logic [2:0]        step_q;
    logic              last_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        dout_q;
    logic [7:0]        mfr_q, dev_q;

    logic              lock_done;
    logic              st_rd, st_last;
    logic [ADDR_W-1:0] st_addr;
    logic [7:0]        st_data;
    logic              t_start, t_drive, t_sample, t_done;

    fcm_lockout #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_lock (
        .clk  (clk),
        .rst_n(rst_n),
        .done (lock_done)
    );

    fcm_seq_gen #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_seq (
        .op     (op_q),
        .step   (step_q),
        .uaddr  (uaddr_q),
        .udata  (udata_q),
        .st_rd  (st_rd),
        .st_last(st_last),
        .st_addr(st_addr),
        .st_data(st_data)
    );

    fcm_bus_timer #(
        .SETUP_CYC (SETUP_CYC),
        .WE_LOW_CYC(WE_LOW_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC),
        .RD_CYC    (RD_CYC)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .start_rd(st_rd),
        .ce_n    (fl_ce_n),
        .we_n    (fl_we_n),
        .oe_n    (fl_oe_n),
        .drive   (t_drive),
        .sample  (t_sample),
        .done    (t_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (is_pe(req_op) && !lock_done) state_d = ST_HOLDOFF;
                    else                              state_d = ST_ISSUE;
                end
            end
            ST_HOLDOFF: if (lock_done) state_d = ST_ISSUE;
            ST_ISSUE:   state_d = ST_BUSWAIT;
            ST_BUSWAIT: begin
                if (t_done) state_d = last_q ? ST_WRAP : ST_ISSUE;
            end
            ST_WRAP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        t_start    = (state_q == ST_ISSUE);
        poll_start = (state_q == ST_WRAP) && is_pe(op_q);
        resp_valid = (state_q == ST_WRAP) && (op_q == OP_IDRD);
        resp_mfr   = mfr_q;
        resp_dev   = dev_q;
        fl_addr    = addr_q;
        fl_dq_out  = dout_q;
        fl_dq_oe   = t_drive;
        unique case (op_q)
            OP_SECT: poll_addr = uaddr_q & SECT_MASK;
            OP_CHIP: poll_addr = '0;
            default: poll_addr = uaddr_q;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_RST;
            uaddr_q <= '0;
            udata_q <= '0;
            step_q  <= '0;
            last_q  <= 1'b0;
            addr_q  <= '0;
            dout_q  <= '0;
            mfr_q   <= '0;
            dev_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= req_op;
                uaddr_q <= req_addr;
                udata_q <= req_data;
                step_q  <= '0;
            end
            if (state_q == ST_ISSUE) begin
                addr_q <= st_addr;
                dout_q <= st_data;
                last_q <= st_last;
            end
            if (state_q == ST_BUSWAIT && t_done && !last_q)
                step_q <= step_q + 1'b1;
            if (t_sample) begin
                if (step_q == 3'd3) mfr_q <= fl_dq_in;
                else                dev_q <= fl_dq_in;
            end
        end
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n));

    // R7
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> $stable(fl_addr));

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(fl_dq_out) && fl_dq_oe));

    // R9
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_we_n) && is_pe(op_q)) |-> lock_done);

    // R10
    poll_only_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_start |-> !resp_valid && is_pe(op_q));

    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_ce_n && !fl_dq_oe));

    // R8
    read_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);

endmodule

// File: tb/flash_cmd_master_tb.sv
module flash_cmd_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WE_LOW     = 3;
    localparam int LOCK       = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_ready, busy, resp_valid, poll_start;
    logic [7:0]  resp_mfr, resp_dev;
    logic [15:0] poll_addr;
    logic        fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [15:0] fl_addr;
    logic [7:0]  fl_dq_out;
    logic [7:0]  fl_dq_in;
    logic [7:0]  id_mfr = 8'h3C, id_dev = 8'hC5;

    assign fl_dq_in = fl_addr[0] ? id_dev : id_mfr;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_master #(
        .POWERUP_NS(LOCK * CLK_PERIOD),
        .CLK_NS    (CLK_PERIOD),
        .WE_LOW_CYC(WE_LOW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .busy(busy),
        .resp_valid(resp_valid), .resp_mfr(resp_mfr), .resp_dev(resp_dev),
        .poll_start(poll_start), .poll_addr(poll_addr),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // bus monitor, sampling on the falling clock edge
    logic [15:0] wr_addr [256];
    logic [7:0]  wr_data [256];
    int          fall_cyc[256];
    logic [15:0] rd_addr [256];
    int wr_total = 0, rd_total = 0, bad_total = 0, poll_total = 0, resp_total = 0;
    logic [15:0] last_poll_addr = '0;
    logic [7:0]  last_mfr = '0, last_dev = '0;
    logic        p_we = 1'b1, p_oe = 1'b1;
    logic [15:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int          low_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_we && !fl_we_n) begin
                wr_addr[wr_total[7:0]]  = fl_addr;
                fall_cyc[wr_total[7:0]] = cyc;
                if (fl_addr != p_addr) bad_total++;
                low_cnt = 1;
            end else if (!fl_we_n) begin
                low_cnt++;
                if (fl_addr != p_addr) bad_total++;
            end
            if (!fl_we_n && (!fl_oe_n || fl_ce_n)) bad_total++;
            if (!p_we && fl_we_n) begin
                wr_data[wr_total[7:0]] = fl_dq_out;
                if (fl_dq_out != p_dq || !fl_dq_oe || low_cnt != WE_LOW) bad_total++;
                wr_total++;
            end
            if (p_oe && !fl_oe_n) begin
                rd_addr[rd_total[7:0]] = fl_addr;
                if (fl_dq_oe || !fl_we_n) bad_total++;
                rd_total++;
            end
            if (poll_start) begin
                poll_total++;
                last_poll_addr = poll_addr;
            end
            if (resp_valid) begin
                resp_total++;
                last_mfr = resp_mfr;
                last_dev = resp_dev;
            end
        end
        p_we   = fl_we_n;
        p_oe   = fl_oe_n;
        p_addr = fl_addr;
        p_dq   = fl_dq_out;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_nwr(input logic [2:0] op);
        case (op)
            3'd0: return 4;
            3'd1, 3'd2: return 6;
            3'd3: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] exp_wa(input logic [2:0] op, input int i, input logic [15:0] ua);
        if (op > 3'd3) return 16'h5555;
        if (op == 3'd3) return (i == 1) ? 16'h2AAA : 16'h5555;
        if (op == 3'd0 && i == 3) return ua;
        if (op == 3'd1 && i == 5) return ua & 16'hF000;
        if (i == 1 || i == 4) return 16'h2AAA;
        return 16'h5555;
    endfunction

    function automatic logic [7:0] exp_wd(input logic [2:0] op, input int i, input logic [7:0] ud);
        if (op > 3'd3) return 8'hF0;
        if (op == 3'd3) begin
            case (i) 0: return 8'hAA; 1: return 8'h55; 2: return 8'h90; default: return 8'hF0; endcase
        end
        case (i)
            0, 3: return (op == 3'd0 && i == 3) ? ud : 8'hAA;
            1, 4: return 8'h55;
            2: return (op == 3'd0) ? 8'hA0 : 8'h80;
            default: return (op == 3'd1) ? 8'h30 : 8'h10;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op) 3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5"; default: return "R6"; endcase
    endfunction

    int first_fall = 0;

    task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d,
                          input bit poke);
        int wb, rb, pb, qb, bb, n, t;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wb = wr_total; rb = rd_total; pb = poll_total; qb = resp_total; bb = bad_total;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        // R11 busy after accept
        check(busy && !req_ready, "R11", "busy after accept", busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_op = 3'd2; req_addr = 16'h1234;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        first_fall = fall_cyc[wb[7:0]];
        n = wr_total - wb;
        check(n == exp_nwr(op), req_of(op), "write count", n, exp_nwr(op));
        for (int i = 0; i < n && i < exp_nwr(op); i++) begin
            check(wr_addr[(wb+i) & 255] == exp_wa(op, i, a), req_of(op), "write addr",
                  wr_addr[(wb+i) & 255], exp_wa(op, i, a));
            check(wr_data[(wb+i) & 255] == exp_wd(op, i, d), req_of(op), "write data",
                  wr_data[(wb+i) & 255], exp_wd(op, i, d));
        end
        // R7 R8 timing flags from monitor
        check(bad_total == bb, "R7", "strobe timing violations", bad_total - bb, 0);
        if (op == 3'd3) begin
            check(rd_total - rb == 2, "R5", "read count", rd_total - rb, 2);
            check(rd_addr[rb & 255] == 16'h0000 && rd_addr[(rb+1) & 255] == 16'h0001,
                  "R5", "read addrs", rd_addr[(rb+1) & 255], 1);
            check(resp_total - qb == 1, "R5", "resp pulses", resp_total - qb, 1);
            check(last_mfr == id_mfr, "R5", "mfr byte", last_mfr, id_mfr);
            check(last_dev == id_dev, "R5", "dev byte", last_dev, id_dev);
        end else begin
            check(rd_total == rb && resp_total == qb, "R5", "no reads", rd_total - rb, 0);
        end
        if (op <= 3'd2) begin
            check(poll_total - pb == 1, "R10", "poll pulses", poll_total - pb, 1);
            check(last_poll_addr == ((op == 3'd0) ? a : (op == 3'd1) ? (a & 16'hF000) : 16'h0),
                  "R10", "poll addr", last_poll_addr,
                  (op == 3'd0) ? a : (op == 3'd1) ? (a & 16'hF000) : 16'h0);
        end else begin
            check(poll_total == pb, "R6", "no poll for non-write op", poll_total - pb, 0);
        end
        check(fl_ce_n && !fl_dq_oe && req_ready, "R11", "idle bus after op", fl_ce_n, 1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int seed;
        int wsave;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1", "bus idle in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
        check(!busy && req_ready, "R1", "handshake in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !busy && req_ready,
              "R1", "idle after reset", busy, 0);

        // R9 id read right after reset is not delayed
        run_op(3'd3, 16'h0, 8'h0, 1'b0);
        check(first_fall < LOCK, "R9", "id read early start cycle", first_fall, LOCK);
        // R9 program held until the window has passed
        run_op(3'd0, 16'h4321, 8'h5A, 1'b0);
        check(first_fall >= LOCK, "R9", "program first fall cycle", first_fall, LOCK);

        // directed corners
        run_op(3'd1, 16'hFFFF, 8'h00, 1'b0);
        run_op(3'd2, 16'hABCD, 8'h00, 1'b0);
        run_op(3'd4, 16'h0000, 8'h00, 1'b0);
        run_op(3'd7, 16'h0000, 8'h00, 1'b0);
        run_op(3'd0, 16'h0000, 8'hFF, 1'b0);

        // R11 request while busy is ignored
        run_op(3'd0, 16'h0F0F, 8'h11, 1'b1);
        wsave = wr_total;
        repeat (40) @(negedge clk);
        check(wr_total == wsave && !busy, "R11", "no cycles after ignored request", wr_total - wsave, 0);

        // constrained random mix
        for (int k = 0; k < 25; k++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 5));
            id_mfr = 8'($urandom);
            id_dev = 8'($urandom);
            run_op(op, 16'($urandom), 8'($urandom), 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule